// File: doc/BRIEF.md
# Dual Address-Register Unit for a Stack CPU

This unit is the address datapath of a small stack-machine processor. It holds two address registers, A and B. B sits logically beneath A, so the pair behaves as a two-entry address stack. With A and B each able to stream through memory with post-increment, a program can walk a source vector and a destination vector without spilling pointers to the data stack.

Each cycle the sequencer may present a 5-bit opcode together with the current top of the data stack (T). Register-only opcodes finish in the cycle they are presented. Memory opcodes raise a read or write strobe for exactly one cycle. The unit then holds the address and write data until the memory signals ready. On that completing edge it updates A or B and tells the data stack to push (the fetched word) or pop (the stored word). Alongside full decode, a memory-access flag is taken straight from one opcode bit, so prefetch logic learns early whether the bus will be needed.

The controller is a three-state machine:

- S_IDLE decodes the opcode. An accepted memory opcode moves it to S_STROBE; any other opcode completes at once.
- S_STROBE drives the strobe. If ready is already high it returns to S_IDLE; otherwise it moves to S_WAIT.
- S_WAIT stays put until ready is high, then returns to S_IDLE.

Top module: `addr_stack_unit`

## Requirements
- R1: After reset, A and B are zero, the unit is in S_IDLE, and both memory strobes are low.
- R2: `mem_flag` equals opcode bit 4. All memory opcodes (0x10 to 0x17) have it set, and the register opcodes 0x00, 0x01 and 0x02 have it clear.
- R3: Fetch via B with increment (0x12) reads at address B, pushes the read word onto T when the access completes, and then increments B. The plain fetch via B (0x16) does the same without the increment.
- R4: Store via B with increment (0x13) writes T to address B, pops T when the access completes, and then increments B. The plain store via B (0x17) does the same without the increment.
- R5: Load A (0x00) moves the old A into B, moves T into A, pops T, and completes in the cycle it is presented.
- R6: Fetch A (0x01) pushes the current A onto T and moves B into A. B keeps its value.
- R7: Load B (0x02) moves T into B and pops T. It makes no memory access.
- R8: Memory opcodes are decoded by field: bit 0 selects store, bit 1 selects B rather than A, and bit 2 suppresses the increment. The A forms are therefore 0x10, 0x11, 0x14 and 0x15.
- R9: A strobe lasts exactly one cycle. Address and write data stay unchanged until `mem_rdy`, and ready may arrive in the strobe cycle itself. Registers change only on the completing edge, which is also the cycle `op_done` is high.
- R10: Address increments wrap modulo 2^W.
- R11: Unhandled opcodes (0x03 to 0x0F and 0x18 to 0x1F) complete at once with no strobe, no push or pop, and no change to A or B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode presented |
| op | input | 5 | Opcode |
| t_in | input | W | Current top of data stack |
| mem_rdata | input | W | Memory read data |
| mem_rdy | input | 1 | Memory access complete |
| mem_flag | output | 1 | Early memory-access flag (opcode bit 4) |
| op_done | output | 1 | Opcode completes this cycle |
| t_out | output | W | Value pushed onto T |
| t_push | output | 1 | Push `t_out` onto the data stack |
| t_pop | output | 1 | Pop the data stack |
| mem_addr | output | W | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | W | Memory write data |

## Verification
The hardest state to reach from the ports is a wrapped B register that has been shuffled through A. Fetch A copies B upward without clearing it, so a wrong value only shows up several opcodes later. The stimulus loads all-ones pointers and then streams through the wrap point. Later accesses expose A through the pushed T value and B through the address of a subsequent fetch. Ready latencies of zero to three cycles cover both the completion inside S_STROBE and the hold through S_WAIT.

// File: rtl/addr_stack_pkg.sv
package addr_stack_pkg;

    localparam int OPW       = 5;
    localparam int MEM_BIT   = 4;
    localparam int RSV_BIT   = 3;
    localparam int NOINC_BIT = 2;
    localparam int SELB_BIT  = 1;
    localparam int STORE_BIT = 0;

    localparam logic [OPW-1:0] OP_LOAD_A      = 5'h00;
    localparam logic [OPW-1:0] OP_FETCH_AREG  = 5'h01;
    localparam logic [OPW-1:0] OP_LOAD_B      = 5'h02;
    localparam logic [OPW-1:0] OP_FETCH_A_INC = 5'h10;
    localparam logic [OPW-1:0] OP_STORE_A_INC = 5'h11;
    localparam logic [OPW-1:0] OP_FETCH_B_INC = 5'h12;
    localparam logic [OPW-1:0] OP_STORE_B_INC = 5'h13;
    localparam logic [OPW-1:0] OP_FETCH_A     = 5'h14;
    localparam logic [OPW-1:0] OP_STORE_A     = 5'h15;
    localparam logic [OPW-1:0] OP_FETCH_B     = 5'h16;
    localparam logic [OPW-1:0] OP_STORE_B     = 5'h17;

    typedef enum logic [1:0] {
        S_IDLE,
        S_STROBE,
        S_WAIT
    } ctl_state_t;

    typedef enum logic [2:0] {
        UPD_NONE,
        UPD_LOAD_A,
        UPD_FETCH_AREG,
        UPD_LOAD_B,
        UPD_INC_A,
        UPD_INC_B
    } upd_kind_t;

    typedef struct packed {
        logic mem;
        logic store;
        logic use_b;
        logic no_inc;
        logic load_a;
        logic fetch_areg;
        logic load_b;
    } op_fields_t;

endpackage

// File: rtl/addr_stack_decode.sv
module addr_stack_decode
    import addr_stack_pkg::*;
(
    input  logic [OPW-1:0] op,
    output op_fields_t     fields,
    output logic           mem_flag
);

    always_comb begin
        fields   = '0;
        mem_flag = op[MEM_BIT];
        if (op[MEM_BIT]) begin
            if (!op[RSV_BIT]) begin
                fields.mem    = 1'b1;
                fields.store  = op[STORE_BIT];
                fields.use_b  = op[SELB_BIT];
                fields.no_inc = op[NOINC_BIT];
            end
        end else begin
            unique case (op)
                OP_LOAD_A:     fields.load_a     = 1'b1;
                OP_FETCH_AREG: fields.fetch_areg = 1'b1;
                OP_LOAD_B:     fields.load_b     = 1'b1;
                default:       fields            = '0;
            endcase
        end
    end

endmodule

// File: rtl/addr_stack_regs.sv
module addr_stack_regs
    import addr_stack_pkg::*;
#(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  upd_kind_t    upd,
    input  logic [W-1:0] t_val,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            unique case (upd)
                UPD_LOAD_A: begin
                    b_q <= a_q;
                    a_q <= t_val;
                end
                UPD_FETCH_AREG: a_q <= b_q;
                UPD_LOAD_B:     b_q <= t_val;
                UPD_INC_A:      a_q <= a_q + ONE;
                UPD_INC_B:      b_q <= b_q + ONE;
                default: begin
                    a_q <= a_q;
                    b_q <= b_q;
                end
            endcase
        end
    end

    AST_LOAD_A_PUSHES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_LOAD_A) |=> (b_q == $past(a_q))); // R5

    AST_FETCH_AREG_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_FETCH_AREG) |=> (a_q == $past(b_q) && b_q == $past(b_q))); // R6

    AST_B_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_INC_B) |=> (b_q == $past(b_q) + ONE)); // R10

endmodule

// File: rtl/addr_stack_ctrl.sv
module addr_stack_ctrl
    import addr_stack_pkg::*;
#(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  op_fields_t   fields,
    input  logic [W-1:0] t_in,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_rdy,
    input  logic [W-1:0] a_q,
    input  logic [W-1:0] b_q,
    output upd_kind_t    upd,
    output logic         op_done,
    output logic [W-1:0] t_out,
    output logic         t_push,
    output logic         t_pop,
    output logic [W-1:0] mem_addr,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_wdata
);

    ctl_state_t   state, state_nx;
    logic         store_q, use_b_q, no_inc_q;
    logic [W-1:0] wdata_q;
    logic         accept, finish;

    assign accept = (state == S_IDLE) && op_valid && fields.mem;
    assign finish = (state != S_IDLE) && mem_rdy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            store_q  <= 1'b0;
            use_b_q  <= 1'b0;
            no_inc_q <= 1'b0;
            wdata_q  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                store_q  <= fields.store;
                use_b_q  <= fields.use_b;
                no_inc_q <= fields.no_inc;
                wdata_q  <= t_in;
            end
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (accept) state_nx = S_STROBE;
            S_STROBE: state_nx = mem_rdy ? S_IDLE : S_WAIT;
            S_WAIT:   if (mem_rdy) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        upd       = UPD_NONE;
        op_done   = 1'b0;
        t_out     = '0;
        t_push    = 1'b0;
        t_pop     = 1'b0;
        mem_addr  = use_b_q ? b_q : a_q;
        mem_wdata = wdata_q;
        mem_rd    = (state == S_STROBE) && !store_q;
        mem_wr    = (state == S_STROBE) && store_q;
        unique case (state)
            S_IDLE: begin
                if (op_valid && !fields.mem) begin
                    op_done = 1'b1;
                    if (fields.load_a) begin
                        upd   = UPD_LOAD_A;
                        t_pop = 1'b1;
                    end else if (fields.fetch_areg) begin
                        upd    = UPD_FETCH_AREG;
                        t_push = 1'b1;
                        t_out  = a_q;
                    end else if (fields.load_b) begin
                        upd   = UPD_LOAD_B;
                        t_pop = 1'b1;
                    end
                end
            end
            S_STROBE, S_WAIT: begin
                if (finish) begin
                    op_done = 1'b1;
                    if (store_q) begin
                        t_pop = 1'b1;
                    end else begin
                        t_push = 1'b1;
                        t_out  = mem_rdata;
                    end
                    if (!no_inc_q) upd = use_b_q ? UPD_INC_B : UPD_INC_A;
                end
            end
            default: upd = UPD_NONE;
        endcase
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> !(mem_rd || mem_wr)); // R9

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R9

    AST_STROBE_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd || mem_wr) |-> $past(op_valid && fields.mem)); // R2

    AST_NO_PUSH_AND_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_push && t_pop)); // R11

endmodule

// File: rtl/addr_stack_unit.sv
module addr_stack_unit
    import addr_stack_pkg::*;
#(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [4:0]   op,
    input  logic [W-1:0] t_in,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_rdy,
    output logic         mem_flag,
    output logic         op_done,
    output logic [W-1:0] t_out,
    output logic         t_push,
    output logic         t_pop,
    output logic [W-1:0] mem_addr,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_wdata
);

    op_fields_t   fields;
    upd_kind_t    upd;
    logic [W-1:0] a_q, b_q;

    addr_stack_decode u_dec (
        .op       (op),
        .fields   (fields),
        .mem_flag (mem_flag)
    );

    addr_stack_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .fields    (fields),
        .t_in      (t_in),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy),
        .a_q       (a_q),
        .b_q       (b_q),
        .upd       (upd),
        .op_done   (op_done),
        .t_out     (t_out),
        .t_push    (t_push),
        .t_pop     (t_pop),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata)
    );

    addr_stack_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .t_val (t_in),
        .a_q   (a_q),
        .b_q   (b_q)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!mem_rd && !mem_wr)); // R1

endmodule

// File: tb/sim_addr_stack_unit.sv
module sim_addr_stack_unit;
    import addr_stack_pkg::*;

    localparam int W          = 21;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 14;

    typedef struct packed {
        logic [4:0]   o;
        logic [W-1:0] tv;
        logic [3:0]   lat;
        logic         ef;
    } vec_t;

    // Pointers: A becomes 20 (destination), B becomes 8 (source)
    localparam vec_t VECS [NV] = '{
        '{OP_LOAD_A,      21'd8,   4'd0, 1'b0},
        '{OP_LOAD_A,      21'd20,  4'd0, 1'b0},
        '{OP_FETCH_B_INC, 21'd0,   4'd0, 1'b1},
        '{OP_STORE_A_INC, 21'd100, 4'd2, 1'b1},
        '{OP_FETCH_B_INC, 21'd0,   4'd1, 1'b1},
        '{OP_STORE_A_INC, 21'd101, 4'd0, 1'b1},
        '{OP_FETCH_A,     21'd0,   4'd1, 1'b1},
        '{OP_STORE_A,     21'd55,  4'd0, 1'b1},
        '{OP_FETCH_A,     21'd0,   4'd0, 1'b1},
        '{5'h07,          21'd9,   4'd0, 1'b0},
        '{5'h18,          21'd9,   4'd0, 1'b1},
        '{OP_FETCH_AREG,  21'd0,   4'd0, 1'b0},
        '{OP_STORE_B,     21'd77,  4'd3, 1'b1},
        '{OP_FETCH_B_INC, 21'd0,   4'd0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [4:0]   op = '0;
    logic [W-1:0] t_in = '0;
    logic [W-1:0] mem_rdata = '0;
    logic         mem_rdy = 1'b0;
    logic         mem_flag, op_done, t_push, t_pop, mem_rd, mem_wr;
    logic [W-1:0] t_out, mem_addr, mem_wdata;

    addr_stack_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .t_in(t_in),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .mem_flag(mem_flag),
        .op_done(op_done), .t_out(t_out), .t_push(t_push), .t_pop(t_pop),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int           checks = 0;
    int           fails = 0;
    logic [W-1:0] ma = '0;
    logic [W-1:0] mb = '0;
    logic [W-1:0] mem [64];

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] o, input logic [W-1:0] tv,
                          input int lat, input logic ef, input string ovr);
        logic         is_mem, st, ub, ni;
        logic         exp_push, exp_pop;
        logic [W-1:0] ea, exp_out;
        string        rq;
        @(negedge clk);
        op_valid = 1'b1; op = o; t_in = tv; mem_rdy = 1'b0;
        #1;
        chk(mem_flag == ef, "R2", "mem_flag", mem_flag, ef);
        is_mem = (o >= 5'h10) && (o <= 5'h17);
        if (!is_mem) begin
            exp_push = 1'b0; exp_pop = 1'b0; exp_out = '0;
            case (o)
                OP_LOAD_A:     begin rq = "R5"; exp_pop = 1'b1; mb = ma; ma = tv; end
                OP_FETCH_AREG: begin rq = "R6"; exp_push = 1'b1; exp_out = ma; ma = mb; end
                OP_LOAD_B:     begin rq = "R7"; exp_pop = 1'b1; mb = tv; end
                default:       rq = "R11";
            endcase
            if (ovr != "") rq = ovr;
            chk(op_done == 1'b1, rq, "op_done", op_done, 1);
            chk(t_push == exp_push, rq, "t_push", t_push, exp_push);
            chk(t_pop == exp_pop, rq, "t_pop", t_pop, exp_pop);
            if (exp_push) chk(t_out == exp_out, rq, "t_out", t_out, exp_out);
            @(negedge clk);
            op_valid = 1'b0;
            #1;
            chk(!mem_rd && !mem_wr, rq, "no strobe", {mem_rd, mem_wr}, 0);
        end else begin
            st = o[0]; ub = o[1]; ni = o[2];
            rq = ub ? (st ? "R4" : "R3") : "R8";
            if (ovr != "") rq = ovr;
            ea = ub ? mb : ma;
            chk(op_done == 1'b0, "R9", "op_done at accept", op_done, 0);
            @(negedge clk);
            op_valid = 1'b0;
            #1;
            chk(mem_rd == !st && mem_wr == st, rq, "strobe", {mem_rd, mem_wr}, {!st, st});
            chk(mem_addr == ea, rq, "address", mem_addr, ea);
            if (st) chk(mem_wdata == tv, rq, "write data", mem_wdata, tv);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                #1;
                chk(!mem_rd && !mem_wr, "R9", "strobe single", {mem_rd, mem_wr}, 0);
                chk(mem_addr == ea, "R9", "address held", mem_addr, ea);
                chk(op_done == 1'b0, "R9", "op_done early", op_done, 0);
            end
            mem_rdy = 1'b1;
            mem_rdata = mem[ea[5:0]];
            #1;
            chk(op_done == 1'b1, "R9", "op_done on ready", op_done, 1);
            if (st) begin
                chk(t_pop && !t_push, rq, "pop", {t_push, t_pop}, 2'b01);
                mem[ea[5:0]] = tv;
            end else begin
                chk(t_push && !t_pop, rq, "push", {t_push, t_pop}, 2'b10);
                chk(t_out == mem[ea[5:0]], rq, "t_out", t_out, mem[ea[5:0]]);
            end
            if (!ni) begin
                if (ub) mb = mb + 1'b1;
                else    ma = ma + 1'b1;
            end
            @(negedge clk);
            mem_rdy = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = W'(i * 7 + 3);
        #1;
        chk(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: A reads back as zero via fetch A, B via plain fetch via B address
        run_op(OP_FETCH_AREG, '0, 0, 1'b0, "R1");
        run_op(OP_FETCH_B, '0, 0, 1'b1, "R1");

        // Table-driven streaming sequence
        for (int i = 0; i < NV; i++)
            run_op(VECS[i].o, VECS[i].tv, int'(VECS[i].lat), VECS[i].ef, "");

        // R7: load B, then verify through a fetch via B address
        run_op(OP_LOAD_B, 21'd40, 0, 1'b0, "");
        run_op(OP_STORE_B_INC, 21'd300, 1, 1'b1, "");
        run_op(OP_FETCH_B, '0, 0, 1'b1, "R7");

        // R10: wrap of B and of A
        run_op(OP_LOAD_B, {W{1'b1}}, 0, 1'b0, "");
        run_op(OP_FETCH_B_INC, '0, 2, 1'b1, "R10");
        run_op(OP_FETCH_B, '0, 0, 1'b1, "R10");
        run_op(OP_LOAD_A, {W{1'b1}}, 0, 1'b0, "");
        run_op(OP_STORE_A_INC, 21'd5, 0, 1'b1, "R10");
        run_op(OP_FETCH_AREG, '0, 0, 1'b0, "R10");

        // R11: ignored codes leave A and B unchanged
        run_op(5'h1F, 21'd3, 0, 1'b1, "");
        run_op(5'h0C, 21'd3, 0, 1'b0, "");
        run_op(OP_FETCH_AREG, '0, 0, 1'b0, "R11");
        run_op(OP_FETCH_B, '0, 0, 1'b1, "R11");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule